// File: doc/BRIEF.md
# Width-Converting FIFO with Programmable Level Flags

The block is a single-clock, one-direction FIFO. Every write stores one 36-bit long word. The read side hands those long words back as one 36-bit piece, two 18-bit pieces or four 9-bit pieces. A configuration sampled during full reset chooses the read width, the piece order and the flag timing.

In standard timing, a read request loads the next piece into a read register. The primary flags then mean "empty" and "full". In first-word-fall-through timing, the head piece sits on the read bus without any request, and a read request moves past it. The primary flags then mean "output ready" and "input ready".

Two level flags, almost-empty and almost-full, compare the stored long-word count with two offsets. The offsets start from a value chosen at reset. After reset, they can be reloaded one bit per clock through a serial chain, or in one cycle from the write bus. A partial reset empties the FIFO but keeps all configuration. Retransmit rewinds the read side to the first long word written since the last reset.

Top module: `busmatch_fifo`

## Requirements
- R1: Each accepted write stores 36 bits of `wr_data`. The read width comes from `cfg_bsel_i`, sampled while `rst_n` is low: 0 selects 36 bits, 1 selects 18 bits, 2 selects 9 bits, and 3 acts as 0.
- R2: With `cfg_little_i`=0, pieces are delivered from the most significant end of the long word: bits 35:18 and then 17:0, or bits 35:27 first for bytes. With `cfg_little_i`=1, the order starts at the least significant end. Pieces are zero-extended on `rd_data`.
- R3: A long word leaves the count only when its last piece is read, so empty is never reported while a partly read long word remains.
- R4: In standard timing (`cfg_fwft_i`=0 at reset), `flag_out` is empty and `flag_in` is full. `rd_data` is a register that changes on the edge that accepts a read and otherwise holds its value.
- R5: In fall-through timing, `flag_out` (output ready) goes high after the edge that writes into an empty FIFO, and `flag_in` is the inverse of full. `rd_data` shows the head piece without a read, and shows zero while the FIFO is empty.
- R6: `almost_empty` is high when count <= empty offset. `almost_full` is high when (DEPTH - count) <= full offset. Both flags change on the same edge as the count.
- R7: On full reset, both offsets take the default chosen by `cfg_offsel_i`: 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256 and 4 gives 1024. Any other value gives 8.
- R8: While `ser_en` is high, each clock shifts `ser_din` into bit 0 of a 22-bit chain. The upper 11 bits of the chain are the full offset and the lower 11 bits are the empty offset.
- R9: `par_load` loads the empty offset from `wr_data[10:0]` and the full offset from `wr_data[28:18]`. It takes priority over `ser_en`.
- R10: Partial reset (`prst_n` low at an edge) clears the stored data, the pointers and the read register. It keeps the read width, piece order, timing mode and offsets.
- R11: Retransmit rewinds reading to the first long word written since the last reset, with the piece position back at zero. A read request in that cycle is dropped, and a write in that cycle is still accepted. Retransmit is valid while no more than DEPTH long words have been written since the last reset.
- R12: A write and a read accepted on the same edge both take effect.
- R13: A write while full and a read while empty are ignored, with no change to the count, pointers or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Synchronous full reset, active low; samples configuration |
| prst_n | input | 1 | Synchronous partial reset, active low |
| cfg_fwft_i | input | 1 | Timing mode: 1 selects fall-through |
| cfg_bsel_i | input | 2 | Read width code |
| cfg_little_i | input | 1 | Piece order: 1 selects little-endian |
| cfg_offsel_i | input | 3 | Default offset selection |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data and parallel offset source |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit request |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| par_load | input | 1 | Parallel offset load |
| rd_data | output | 36 | Read data, zero-extended piece |
| flag_out | output | 1 | Empty (standard) or output ready (fall-through) |
| flag_in | output | 1 | Full (standard) or input ready (fall-through) |
| almost_empty | output | 1 | Count at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The interesting overlap is a write landing on the same edge as the read of a long word's last piece. One moves the count up and the other moves it down, so the two must cancel. Just as important are the edge cases of that overlap: a write blocked by full while a read frees space, and a read blocked by empty while a write fills it, where only the flag from before the edge may decide. The bench provokes these with back-to-back simultaneous cycles at full and empty, and with random traffic in every width and timing mode. A queue-based model, which tracks the count in long words and the piece position separately, judges every flag and `rd_data` on every clock.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  // Read width codes
  localparam logic [1:0] BUS_LONG = 2'd0;
  localparam logic [1:0] BUS_WORD = 2'd1;
  localparam logic [1:0] BUS_BYTE = 2'd2;

  // Default offset picked at full reset
  function automatic int default_off(input logic [2:0] sel);
    case (sel)
      3'd1:    return 16;
      3'd2:    return 64;
      3'd3:    return 256;
      3'd4:    return 1024;
      default: return 8;
    endcase
  endfunction

  // Index of the final piece of a long word for a given width
  function automatic logic [1:0] last_idx(input logic [1:0] bsel);
    case (bsel)
      BUS_WORD: return 2'd1;
      BUS_BYTE: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

  // Extract piece number idx of a long word, zero-extended
  function automatic logic [35:0] pick_piece(input logic [35:0] w,
                                             input logic [1:0]  bsel,
                                             input logic        little,
                                             input logic [1:0]  idx);
    logic [1:0] k;
    logic       h;
    case (bsel)
      BUS_WORD: begin
        h = little ? idx[0] : ~idx[0];
        return {18'd0, w[18*h +: 18]};
      end
      BUS_BYTE: begin
        k = little ? idx : (2'd3 - idx);
        return {27'd0, w[9*k +: 9]};
      end
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/bmf_cfg.sv
module bmf_cfg #(
  parameter int OFFW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_fwft_i,
  input  logic [1:0]      cfg_bsel_i,
  input  logic            cfg_little_i,
  input  logic [2:0]      cfg_offsel_i,
  input  logic            ser_en,
  input  logic            ser_din,
  input  logic            par_load,
  input  logic [OFFW-1:0] par_ae,
  input  logic [OFFW-1:0] par_af,
  output logic            fwft,
  output logic [1:0]      bsel,
  output logic            little,
  output logic [OFFW-1:0] ae_off,
  output logic [OFFW-1:0] af_off
);
  import bmf_pkg::*;

  logic [2*OFFW-1:0] chain;
  assign chain = {af_off, ae_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwft   <= cfg_fwft_i;
      bsel   <= (cfg_bsel_i == 2'd3) ? BUS_LONG : cfg_bsel_i;
      little <= cfg_little_i;
      ae_off <= OFFW'(default_off(cfg_offsel_i));
      af_off <= OFFW'(default_off(cfg_offsel_i));
    end else if (par_load) begin
      ae_off <= par_ae;
      af_off <= par_af;
    end else if (ser_en) begin
      {af_off, ae_off} <= {chain[2*OFFW-2:0], ser_din};
    end
  end
endmodule

// File: rtl/bmf_store.sv
module bmf_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prst_n,
  input  logic          we,
  input  logic [35:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [35:0]   rdata,
  output logic [AW:0]   wr_ptr
);
  logic [35:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !prst_n) wr_ptr <= '0;
    else if (we)           wr_ptr <= wr_ptr + 1'b1;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bmf_rdpath.sv
module bmf_rdpath #(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prst_n,
  input  logic        retx,
  input  logic        take,
  input  logic        fwft,
  input  logic [1:0]  bsel,
  input  logic        little,
  input  logic        empty,
  input  logic [35:0] head,
  output logic [AW:0] rd_ptr,
  output logic [1:0]  pidx,
  output logic        rd_pop,
  output logic [35:0] rd_data
);
  import bmf_pkg::*;

  logic        at_last;
  logic [35:0] cur_piece;
  logic [35:0] rd_q;

  assign at_last   = (pidx == last_idx(bsel));
  assign rd_pop    = take && at_last;
  assign cur_piece = pick_piece(head, bsel, little, pidx);

  always_ff @(posedge clk) begin
    if (!rst_n || !prst_n) begin
      rd_ptr <= '0;
      pidx   <= '0;
      rd_q   <= '0;
    end else if (retx) begin
      rd_ptr <= '0;
      pidx   <= '0;
    end else if (take) begin
      rd_q <= cur_piece;
      if (at_last) begin
        pidx   <= '0;
        rd_ptr <= rd_ptr + 1'b1;
      end else begin
        pidx <= pidx + 1'b1;
      end
    end
  end

  assign rd_data = fwft ? (empty ? 36'd0 : cur_piece) : rd_q;
endmodule

// File: rtl/busmatch_fifo.sv
module busmatch_fifo #(
  parameter int DEPTH = 64,
  parameter int OFFW  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prst_n,
  input  logic        cfg_fwft_i,
  input  logic [1:0]  cfg_bsel_i,
  input  logic        cfg_little_i,
  input  logic [2:0]  cfg_offsel_i,
  input  logic        wr_en,
  input  logic [35:0] wr_data,
  input  logic        rd_en,
  input  logic        retx,
  input  logic        ser_en,
  input  logic        ser_din,
  input  logic        par_load,
  output logic [35:0] rd_data,
  output logic        flag_out,
  output logic        flag_in,
  output logic        almost_empty,
  output logic        almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic            fwft, little;
  logic [1:0]      bsel;
  logic [OFFW-1:0] ae_off, af_off;
  logic [AW:0]     wr_ptr, rd_ptr, cnt, free_cnt;
  logic [1:0]      pidx;
  logic [35:0]     head;
  logic            empty, full, wr_fire, take, rd_pop;

  bmf_cfg #(.OFFW(OFFW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_fwft_i(cfg_fwft_i), .cfg_bsel_i(cfg_bsel_i),
    .cfg_little_i(cfg_little_i), .cfg_offsel_i(cfg_offsel_i),
    .ser_en(ser_en), .ser_din(ser_din), .par_load(par_load),
    .par_ae(wr_data[OFFW-1:0]), .par_af(wr_data[18 +: OFFW]),
    .fwft(fwft), .bsel(bsel), .little(little),
    .ae_off(ae_off), .af_off(af_off)
  );

  bmf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
    .we(wr_fire), .wdata(wr_data),
    .raddr(rd_ptr[AW-1:0]), .rdata(head), .wr_ptr(wr_ptr)
  );

  bmf_rdpath #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .retx(retx),
    .take(take), .fwft(fwft), .bsel(bsel), .little(little),
    .empty(empty), .head(head),
    .rd_ptr(rd_ptr), .pidx(pidx), .rd_pop(rd_pop), .rd_data(rd_data)
  );

  // Named events used by the bound checker
  assign cnt      = wr_ptr - rd_ptr;
  assign free_cnt = DEPTH_C - cnt;
  assign empty    = (cnt == '0);
  assign full     = (cnt == DEPTH_C);
  assign wr_fire  = wr_en && !full && prst_n;
  assign take     = rd_en && !empty && !retx && prst_n;

  assign flag_out     = fwft ? !empty : empty;
  assign flag_in      = fwft ? !full  : full;
  assign almost_empty = 32'(cnt) <= 32'(ae_off);
  assign almost_full  = 32'(free_cnt) <= 32'(af_off);
endmodule

// File: rtl/bmf_chk.sv
module bmf_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        prst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        retx,
  input logic        wr_fire,
  input logic        rd_pop,
  input logic [AW:0] cnt,
  input logic [AW:0] rd_ptr,
  input logic [1:0]  pidx,
  input logic        flag_out,
  input logic [3:0]  cfg_word
);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);

  assert_full_write_dropped_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == DEPTH_C && wr_en && !rd_en && !retx && prst_n) |=> cnt == DEPTH_C);

  assert_empty_read_dropped_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_en && !wr_en && !retx && prst_n) |=> (cnt == '0 && $stable(rd_ptr)));

  assert_both_sides_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_pop && !retx && prst_n) |=> $stable(cnt));

  assert_or_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[3] && cnt == '0 && wr_en && !retx && prst_n) |=> flag_out);

  assert_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (retx && prst_n) |=> (rd_ptr == '0 && pidx == 2'd0));

  assert_keep_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |=> $stable(cfg_word));

  assert_no_partial_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (pidx == 2'd0));
endmodule

bind busmatch_fifo bmf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
  .wr_en(wr_en), .rd_en(rd_en), .retx(retx),
  .wr_fire(wr_fire), .rd_pop(rd_pop), .cnt(cnt),
  .rd_ptr(rd_ptr), .pidx(pidx), .flag_out(flag_out),
  .cfg_word({fwft, bsel, little})
);

// File: tb/tb_busmatch_fifo.sv
module tb_busmatch_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 0;
  logic        rst_n = 0, prst_n = 1;
  logic        cfg_fwft_i = 0, cfg_little_i = 0;
  logic [1:0]  cfg_bsel_i = 0;
  logic [2:0]  cfg_offsel_i = 0;
  logic        wr_en = 0, rd_en = 0, retx = 0;
  logic        ser_en = 0, ser_din = 0, par_load = 0;
  logic [35:0] wr_data = 0;
  logic [35:0] rd_data;
  logic        flag_out, flag_in, almost_empty, almost_full;

  busmatch_fifo #(.DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int    total = 0, bad = 0;
  bit    chk_on = 0, done = 0;
  string cur_req = "R7";

  // ---- behavioural reference model ----
  logic [35:0] hist[$];
  int          rdi = 0, pc = 0;
  bit          m_fwft = 0, m_little = 0;
  int          m_bsel = 0, m_ae = 8, m_af = 8;
  logic [35:0] m_rdq = 0;

  function automatic int n_pieces();
    return (m_bsel == 1) ? 2 : (m_bsel == 2) ? 4 : 1;
  endfunction

  function automatic logic [35:0] m_piece(input logic [35:0] w, input int k);
    int np, sz, sh;
    np = n_pieces();
    if (np == 1) return w;
    sz = 36 / np;
    sh = m_little ? k : (np - 1 - k);
    return (w >> (sz * sh)) & ((36'd1 << sz) - 36'd1);
  endfunction

  function automatic int m_count();
    return hist.size() - rdi;
  endfunction

  task automatic model_edge();
    int c, ch;
    int offs[5] = '{8, 16, 64, 256, 1024};
    if (!rst_n) begin
      m_fwft = cfg_fwft_i; m_little = cfg_little_i;
      m_bsel = (cfg_bsel_i == 3) ? 0 : int'(cfg_bsel_i);
      m_ae = (cfg_offsel_i <= 4) ? offs[cfg_offsel_i] : 8;
      m_af = m_ae;
      hist.delete(); rdi = 0; pc = 0; m_rdq = 0;
      return;
    end
    if (par_load) begin
      m_ae = int'(wr_data[10:0]);
      m_af = int'(wr_data[28:18]);
    end else if (ser_en) begin
      ch = (((m_af << 11) | m_ae) << 1 | int'(ser_din)) & 32'h3F_FFFF;
      m_af = ch >> 11;
      m_ae = ch & 32'h7FF;
    end
    if (!prst_n) begin
      hist.delete(); rdi = 0; pc = 0; m_rdq = 0;
      return;
    end
    c = m_count();
    if (retx) begin
      rdi = 0; pc = 0;
    end else if (rd_en && c > 0) begin
      m_rdq = m_piece(hist[rdi], pc);
      pc++;
      if (pc == n_pieces()) begin pc = 0; rdi++; end
    end
    if (wr_en && c < DEPTH) hist.push_back(wr_data);
  endtask

  task automatic check(input string sig, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    int c;
    bit e, f;
    logic [35:0] exp_d;
    c = m_count();
    e = (c == 0);
    f = (c == DEPTH);
    exp_d = m_fwft ? (e ? 36'd0 : m_piece(hist[rdi], pc)) : m_rdq;
    check("flag_out", 36'(flag_out), 36'(m_fwft ? !e : e));
    check("flag_in",  36'(flag_in),  36'(m_fwft ? !f : f));
    check("almost_empty", 36'(almost_empty), 36'(c <= m_ae));
    check("almost_full",  36'(almost_full),  36'((DEPTH - c) <= m_af));
    check("rd_data", rd_data, exp_d);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (chk_on) compare();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; retx = 0; ser_en = 0; par_load = 0; prst_n = 1;
  endtask

  task automatic do_reset(input bit fw, input logic [1:0] bs, input bit le, input logic [2:0] os);
    idle();
    cfg_fwft_i = fw; cfg_bsel_i = bs; cfg_little_i = le; cfg_offsel_i = os;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    chk_on = 1;
  endtask

  task automatic wr(input logic [35:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1; tick(); end
    rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R7: reset state, standard timing, long words, default offset 8
    do_reset(0, 2'd0, 0, 3'd0);
    cur_req = "R7"; tick();
    cur_req = "R6";
    for (int i = 0; i < DEPTH; i++) wr(36'h1_0000_0000 + 36'(i * 7));
    cur_req = "R13"; wr(36'hBAD); wr(36'hBAD);
    cur_req = "R4"; rd(DEPTH);
    cur_req = "R13"; rd(2);
    // R12: simultaneous write and read, also at the full boundary
    cur_req = "R12";
    for (int i = 0; i < 3; i++) wr(36'(i + 100));
    for (int i = 0; i < 6; i++) begin wr_en = 1; rd_en = 1; wr_data = 36'(i + 200); tick(); end
    idle();
    while (m_count() < DEPTH) wr(36'h55);
    for (int i = 0; i < 3; i++) begin wr_en = 1; rd_en = 1; wr_data = 36'h77; tick(); end
    idle(); rd(2 * DEPTH);
    wr_en = 1; rd_en = 1; wr_data = 36'h99; tick(); idle();
    // R5: fall-through, byte width, big-endian
    do_reset(1, 2'd2, 0, 3'd1);
    cur_req = "R5"; tick(); wr(36'h9_1234_5678); tick();
    cur_req = "R3"; rd(3); tick(); rd(1); tick();
    // R2: word width, little-endian, standard timing
    do_reset(0, 2'd1, 1, 3'd4);
    cur_req = "R2";
    for (int i = 0; i < 4; i++) wr(36'hA_BCDE_F012 ^ 36'(i << 20));
    rd(9);
    // R10: partial reset keeps width/order/offsets
    cur_req = "R10";
    wr(36'h3_3333_4444); wr(36'h5_5555_6666); rd(1);
    prst_n = 0; wr_en = 1; rd_en = 1; tick(); idle();
    wr(36'h7_7777_8888); rd(3);
    // R11: retransmit
    cur_req = "R11";
    for (int i = 0; i < 5; i++) wr(36'(i * 9 + 1));
    rd(3);
    retx = 1; rd_en = 1; wr_en = 1; wr_data = 36'hEE; tick(); idle();
    rd(14);
    // R8: serial offset load; R9: parallel load
    cur_req = "R8";
    ser_en = 1;
    for (int i = 0; i < 22; i++) begin ser_din = (i % 3 == 0); tick(); end
    ser_en = 0;
    for (int i = 0; i < 6; i++) wr(36'(i));
    cur_req = "R9";
    par_load = 1; ser_en = 1; wr_data = {7'd0, 11'd3, 7'd0, 11'd4}; tick(); idle();
    for (int i = 0; i < 8; i++) wr(36'(i));
    rd(20);
    // R1: random traffic in every width, order and timing mode
    cur_req = "R1";
    for (int cfg = 0; cfg < 16; cfg++) begin
      do_reset(cfg[0], cfg[2:1], cfg[3], 3'(cfg % 6));
      for (int i = 0; i < 400; i++) begin
        wr_en   = ($urandom % 3) != 0;
        rd_en   = ($urandom % 2) != 0;
        wr_data = {$urandom, 4'($urandom)};
        retx    = (hist.size() < DEPTH) && (($urandom % 40) == 0);
        prst_n  = ($urandom % 90) != 0;
        ser_en  = ($urandom % 30) == 0;
        ser_din = $urandom % 2;
        par_load = ($urandom % 60) == 0;
        tick();
      end
      idle();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule